// File: doc/BRIEF.md
# SD Command Issue Controller

This block belongs to an SD host controller and turns a register write into a command launch on the SD bus. Software writes a 16-bit command register through a byte-enabled port. A write that touches the upper byte starts a command. The block then drives a one-cycle start strobe that carries the 6-bit command index, the 32-bit argument and a 48-bit command frame with the index at bits 45:40. A command-busy flag stays high from the launch until the response-complete input arrives.

The 2-bit command type selects how the data path reacts. A normal command leaves it alone. A successful suspend releases the bus, which drops read wait and busy checking. A successful resume brings the transfer back, and for a write it holds the write start until the data line is no longer busy. An abort stops reads into the buffer when a read is in progress, or stops driving the data line when a write is in progress. A software reset clears the register and returns every data-path control to idle.

Top module: `sdcmd_issue`

## Requirements
- R1: After the synchronous reset, `cmd_start`, `bus_released`, `read_wait_en`, `busy_chk_en`, `wr_restart`, `stop_buf_rd` and `stop_dat_drv` are 0, and `cmd_inhibit` is 1.
- R2: A write with `wr_be[1]`=1 makes `cmd_start` high for exactly the next cycle. In that cycle `cmd_index` is `wr_data[13:8]`, `cmd_argument` is `cmd_arg`, and `cmd_frame` is {2'b01, index, argument, 7'b0, 1'b1}.
- R3: A write with only `wr_be[0]`=1 starts no command. It stores the type from `wr_data[7:6]`, which a later write of the upper byte alone then uses. With `wr_be[0]`=0, `wr_data[7:0]` is ignored.
- R4: A write to the upper byte launches a command even while `cmd_inhibit` is 1.
- R5: `cmd_inhibit` goes to 1 in the cycle after a launch and to 0 in the cycle after `resp_done`. When a launch and `resp_done` fall in the same cycle, it stays 1.
- R6: The type encoding is 00 normal, 01 suspend, 10 resume and 11 abort. A normal command changes no data-path output.
- R7: A suspend that completes with `resp_ok`=1 sets `bus_released` and forces `read_wait_en` and `busy_chk_en` to 0.
- R8: A suspend that completes with `resp_ok`=0 leaves every data-path output unchanged.
- R9: A resume that completes with `resp_ok`=1 clears `bus_released`. When `xfer_dir`=1 (write), the block holds `busy_chk_en` high. One cycle after it first samples `dat_busy`=0, it pulses `wr_restart` for one cycle.
- R10: An abort launched while `xfer_act`=1 sets the sticky `stop_buf_rd` if `xfer_dir`=0, or the sticky `stop_dat_drv` if `xfer_dir`=1.
- R11: `soft_rst` clears the stored type and index and forces all data-path outputs to 0 in the next cycle. It does not change `cmd_inhibit`.
- R12: While the transfer is running and not stopped, `read_wait_en` follows `xfer_act & ~xfer_dir` and `busy_chk_en` follows `xfer_act & xfer_dir`, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset of register and data-path controls |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables, bit 1 = upper byte |
| wr_data | input | 16 | Register write data |
| cmd_arg | input | 32 | Command argument |
| resp_done | input | 1 | Command response complete |
| resp_ok | input | 1 | Response result, 1 = success |
| xfer_act | input | 1 | Data transfer in progress |
| xfer_dir | input | 1 | Transfer direction, 1 = write |
| dat_busy | input | 1 | Data line busy |
| cmd_start | output | 1 | One-cycle command start strobe |
| cmd_index | output | 6 | Launched command index |
| cmd_argument | output | 32 | Launched argument |
| cmd_frame | output | 48 | Command frame without CRC |
| cmd_inhibit | output | 1 | Command outstanding |
| bus_released | output | 1 | Bus released after suspend |
| read_wait_en | output | 1 | Read wait enable |
| busy_chk_en | output | 1 | Busy check enable |
| wr_restart | output | 1 | Write restart pulse after resume |
| stop_buf_rd | output | 1 | Reads into buffer stopped |
| stop_dat_drv | output | 1 | Data line drive stopped |

## Verification
The bench builds the block with its default parameters: a 16-bit register with two byte lanes, the index at bits 13:8, the type at bits 7:6 and a 32-bit argument. With two lanes it can try full writes, lower-only writes and upper-only writes, including an upper-only write whose ignored low byte would have encoded an abort. The default widths also let it check the exact frame layout and every type code against read and write transfer directions, with `dat_busy` held high across a resume.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [1:0] {
    CT_NORMAL  = 2'b00,
    CT_SUSPEND = 2'b01,
    CT_RESUME  = 2'b10,
    CT_ABORT   = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    PH_RUN      = 2'b00,
    PH_RELEASED = 2'b01,
    PH_RESWAIT  = 2'b10
  } dp_phase_e;

endpackage

// File: rtl/sdcmd_regfile.sv
module sdcmd_regfile #(
  parameter int REG_W    = 16,
  parameter int IDX_W    = 6,
  parameter int IDX_LSB  = 8,
  parameter int TYPE_W   = 2,
  parameter int TYPE_LSB = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  soft_rst,
  input  logic                  wr_en,
  input  logic [REG_W/8-1:0]    wr_be,
  input  logic [REG_W-1:0]      wr_data,
  output logic                  launch,
  output logic [IDX_W-1:0]      launch_idx,
  output logic [TYPE_W-1:0]     launch_type
);

  localparam int BE_W        = REG_W / 8;
  localparam int LAUNCH_BYTE = BE_W - 1;
  localparam logic [REG_W-1:0] IDX_MASK  = REG_W'(((1 << IDX_W) - 1) << IDX_LSB);
  localparam logic [REG_W-1:0] TYPE_MASK = REG_W'(((1 << TYPE_W) - 1) << TYPE_LSB);
  localparam logic [REG_W-1:0] LIVE_MASK = IDX_MASK | TYPE_MASK;

  logic [IDX_W-1:0]  idx_q,  idx_mrg;
  logic [TYPE_W-1:0] type_q, type_mrg;
  logic              rsvd_unused;

  // each field bit takes new data only when its own byte lane is enabled
  for (genvar i = 0; i < IDX_W; i++) begin : g_idx
    localparam int POS = IDX_LSB + i;
    assign idx_mrg[i] = wr_be[POS/8] ? wr_data[POS] : idx_q[i];
  end

  for (genvar i = 0; i < TYPE_W; i++) begin : g_type
    localparam int POS = TYPE_LSB + i;
    assign type_mrg[i] = wr_be[POS/8] ? wr_data[POS] : type_q[i];
  end

  assign rsvd_unused = ^(wr_data & ~LIVE_MASK);

  assign launch      = wr_en & wr_be[LAUNCH_BYTE] & ~soft_rst;
  assign launch_idx  = idx_mrg;
  assign launch_type = type_mrg;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      idx_q  <= '0;
      type_q <= '0;
    end else if (wr_en) begin
      idx_q  <= idx_mrg;
      type_q <= type_mrg;
    end
  end

endmodule

// File: rtl/sdcmd_launcher.sv
module sdcmd_launcher #(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int TYPE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     launch,
  input  logic [IDX_W-1:0]         launch_idx,
  input  logic [TYPE_W-1:0]        launch_type,
  input  logic [ARG_W-1:0]         arg_in,
  input  logic                     resp_done,
  output logic                     start_q,
  output logic [IDX_W-1:0]         idx_q,
  output logic [ARG_W-1:0]         arg_q,
  output logic [IDX_W+ARG_W+9:0]   frame_q,
  output logic                     inhibit_q,
  output logic                     done_evt,
  output logic [TYPE_W-1:0]        done_type
);

  localparam int FRAME_W = IDX_W + ARG_W + 10;
  localparam int CRC_W   = 7;

  logic [TYPE_W-1:0]  kind_q;
  logic [FRAME_W-1:0] frame_n;

  // start bit 0, transmitter bit 1, index, argument, CRC slot, end bit
  assign frame_n = {2'b01, launch_idx, arg_in, {CRC_W{1'b0}}, 1'b1};

  assign done_evt  = resp_done & inhibit_q;
  assign done_type = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= 1'b0;
      idx_q     <= '0;
      arg_q     <= '0;
      frame_q   <= '0;
      kind_q    <= '0;
      inhibit_q <= 1'b1;
    end else begin
      start_q <= launch;
      if (launch) begin
        idx_q     <= launch_idx;
        arg_q     <= arg_in;
        frame_q   <= frame_n;
        kind_q    <= launch_type;
        inhibit_q <= 1'b1;
      end else if (done_evt) begin
        inhibit_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdcmd_dpctl.sv
module sdcmd_dpctl
  import sdcmd_pkg::*;
#(
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              abort_go,
  input  logic              done_evt,
  input  logic [TYPE_W-1:0] done_type,
  input  logic              done_ok,
  input  logic              xfer_act,
  input  logic              xfer_dir,
  input  logic              dat_busy,
  output logic              released_q,
  output logic              rdwait_q,
  output logic              bsychk_q,
  output logic              restart_q,
  output logic              stop_rd_q,
  output logic              stop_drv_q
);

  dp_phase_e ph_q, ph_n;
  logic      srd_n, sdrv_n, restart_n;
  logic      rdwait_n, bsychk_n, released_n;
  cmd_kind_e kind;

  assign kind = cmd_kind_e'(done_type[1:0]);

  always_comb begin
    ph_n      = ph_q;
    srd_n     = stop_rd_q;
    sdrv_n    = stop_drv_q;
    restart_n = 1'b0;
    if (soft_rst) begin
      ph_n   = PH_RUN;
      srd_n  = 1'b0;
      sdrv_n = 1'b0;
    end else begin
      if (ph_q == PH_RESWAIT && !dat_busy) begin
        ph_n      = PH_RUN;
        restart_n = 1'b1;
      end
      if (done_evt && done_ok) begin
        case (kind)
          CT_SUSPEND: ph_n = PH_RELEASED;
          CT_RESUME:  ph_n = xfer_dir ? PH_RESWAIT : PH_RUN;
          default:    ;
        endcase
      end
      if (abort_go && xfer_act) begin
        if (xfer_dir) sdrv_n = 1'b1;
        else          srd_n  = 1'b1;
      end
    end
  end

  always_comb begin
    released_n = ~soft_rst & (ph_n == PH_RELEASED);
    rdwait_n   = ~soft_rst & (ph_n == PH_RUN) & xfer_act & ~xfer_dir & ~srd_n;
    bsychk_n   = ~soft_rst & (((ph_n == PH_RUN) & xfer_act & xfer_dir & ~sdrv_n)
                              | (ph_n == PH_RESWAIT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_RUN;
      released_q <= 1'b0;
      rdwait_q   <= 1'b0;
      bsychk_q   <= 1'b0;
      restart_q  <= 1'b0;
      stop_rd_q  <= 1'b0;
      stop_drv_q <= 1'b0;
    end else begin
      ph_q       <= ph_n;
      released_q <= released_n;
      rdwait_q   <= rdwait_n;
      bsychk_q   <= bsychk_n;
      restart_q  <= restart_n;
      stop_rd_q  <= srd_n;
      stop_drv_q <= sdrv_n;
    end
  end

endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
  import sdcmd_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int IDX_W    = 6,
  parameter int IDX_LSB  = 8,
  parameter int TYPE_W   = 2,
  parameter int TYPE_LSB = 6,
  parameter int ARG_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   soft_rst,
  input  logic                   wr_en,
  input  logic [REG_W/8-1:0]     wr_be,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [ARG_W-1:0]       cmd_arg,
  input  logic                   resp_done,
  input  logic                   resp_ok,
  input  logic                   xfer_act,
  input  logic                   xfer_dir,
  input  logic                   dat_busy,
  output logic                   cmd_start,
  output logic [IDX_W-1:0]       cmd_index,
  output logic [ARG_W-1:0]       cmd_argument,
  output logic [IDX_W+ARG_W+9:0] cmd_frame,
  output logic                   cmd_inhibit,
  output logic                   bus_released,
  output logic                   read_wait_en,
  output logic                   busy_chk_en,
  output logic                   wr_restart,
  output logic                   stop_buf_rd,
  output logic                   stop_dat_drv
);

  logic              launch;
  logic [IDX_W-1:0]  launch_idx;
  logic [TYPE_W-1:0] launch_type;
  logic              done_evt;
  logic [TYPE_W-1:0] done_type;
  logic              abort_go;

  sdcmd_regfile #(
    .REG_W(REG_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
    .TYPE_W(TYPE_W), .TYPE_LSB(TYPE_LSB)
  ) u_reg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .launch(launch), .launch_idx(launch_idx), .launch_type(launch_type)
  );

  sdcmd_launcher #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .TYPE_W(TYPE_W)
  ) u_launch (
    .clk(clk), .rst(rst),
    .launch(launch), .launch_idx(launch_idx), .launch_type(launch_type),
    .arg_in(cmd_arg), .resp_done(resp_done),
    .start_q(cmd_start), .idx_q(cmd_index), .arg_q(cmd_argument),
    .frame_q(cmd_frame), .inhibit_q(cmd_inhibit),
    .done_evt(done_evt), .done_type(done_type)
  );

  assign abort_go = launch & (launch_type == TYPE_W'(CT_ABORT));

  sdcmd_dpctl #(
    .TYPE_W(TYPE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .abort_go(abort_go), .done_evt(done_evt), .done_type(done_type),
    .done_ok(resp_ok), .xfer_act(xfer_act), .xfer_dir(xfer_dir),
    .dat_busy(dat_busy),
    .released_q(bus_released), .rdwait_q(read_wait_en),
    .bsychk_q(busy_chk_en), .restart_q(wr_restart),
    .stop_rd_q(stop_buf_rd), .stop_drv_q(stop_dat_drv)
  );

endmodule

// File: rtl/sdcmd_issue_chk.sv
module sdcmd_issue_chk #(
  parameter int REG_W = 16,
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   soft_rst,
  input logic                   wr_en,
  input logic [REG_W/8-1:0]     wr_be,
  input logic [REG_W-1:0]       wr_data,
  input logic [ARG_W-1:0]       cmd_arg,
  input logic                   resp_done,
  input logic                   resp_ok,
  input logic                   xfer_act,
  input logic                   xfer_dir,
  input logic                   dat_busy,
  input logic                   cmd_start,
  input logic [IDX_W-1:0]       cmd_index,
  input logic [ARG_W-1:0]       cmd_argument,
  input logic [IDX_W+ARG_W+9:0] cmd_frame,
  input logic                   cmd_inhibit,
  input logic                   bus_released,
  input logic                   read_wait_en,
  input logic                   busy_chk_en,
  input logic                   wr_restart,
  input logic                   stop_buf_rd,
  input logic                   stop_dat_drv
);

  localparam int TOP_BYTE = REG_W / 8 - 1;

  // R2
  start_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> $past(wr_en && wr_be[TOP_BYTE]));

  // R3
  low_only_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_be[TOP_BYTE]) |=> !cmd_start);

  // R5
  inhibit_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> cmd_inhibit);

  // R7
  released_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bus_released |-> (!read_wait_en && !busy_chk_en));

  // R9
  restart_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wr_restart |-> $past(!dat_busy));

  // R10
  stop_rd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_buf_rd && !soft_rst) |=> stop_buf_rd);

  // R10
  stop_drv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_dat_drv && !soft_rst) |=> stop_dat_drv);

  // R11
  soft_clears_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!stop_buf_rd && !stop_dat_drv && !bus_released
                  && !read_wait_en && !busy_chk_en));

endmodule

bind sdcmd_issue sdcmd_issue_chk #(.REG_W(REG_W), .IDX_W(IDX_W), .ARG_W(ARG_W)) u_chk (.*);

// File: tb/sdcmd_issue_test.sv
`timescale 1ns/1ps
module sdcmd_issue_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic [31:0] cmd_arg = '0;
  logic        resp_done = 1'b0, resp_ok = 1'b0;
  logic        xfer_act = 1'b0, xfer_dir = 1'b0, dat_busy = 1'b0;
  logic        cmd_start, cmd_inhibit, bus_released, read_wait_en;
  logic        busy_chk_en, wr_restart, stop_buf_rd, stop_dat_drv;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_argument;
  logic [47:0] cmd_frame;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  sdcmd_issue uut (.*);

  // behavioural reference state
  int          m_idx_r, m_typ_r, m_idx, m_kind, m_ph;
  logic [31:0] m_arg;
  bit          m_start, m_inh, m_rel, m_rw, m_bc, m_rs, m_srd, m_sdrv;

  always @(posedge clk) begin
    if (rst) begin
      m_idx_r = 0; m_typ_r = 0; m_idx = 0; m_kind = 0; m_ph = 0; m_arg = 0;
      m_start = 0; m_inh = 1; m_rel = 0; m_rw = 0; m_bc = 0; m_rs = 0;
      m_srd = 0; m_sdrv = 0;
    end else begin
      int  ni, nt, old_kind;
      bit  go, fin;
      ni = wr_be[1] ? int'(wr_data[13:8]) : m_idx_r;
      nt = wr_be[0] ? int'(wr_data[7:6]) : m_typ_r;
      go = wr_en && wr_be[1] && !soft_rst;
      fin = resp_done && m_inh;
      old_kind = m_kind;
      if (soft_rst) begin m_idx_r = 0; m_typ_r = 0; end
      else if (wr_en) begin m_idx_r = ni; m_typ_r = nt; end
      m_start = go;
      if (go) begin m_idx = ni; m_arg = cmd_arg; m_kind = nt; m_inh = 1; end
      else if (fin) m_inh = 0;
      m_rs = 0;
      if (soft_rst) begin
        m_ph = 0; m_srd = 0; m_sdrv = 0;
      end else begin
        if (m_ph == 2 && !dat_busy) begin m_ph = 0; m_rs = 1; end
        if (fin && resp_ok && old_kind == 1) m_ph = 1;
        if (fin && resp_ok && old_kind == 2) m_ph = xfer_dir ? 2 : 0;
        if (go && nt == 3 && xfer_act) begin
          if (xfer_dir) m_sdrv = 1; else m_srd = 1;
        end
      end
      m_rel = !soft_rst && m_ph == 1;
      m_rw  = !soft_rst && m_ph == 0 && xfer_act && !xfer_dir && !m_srd;
      m_bc  = !soft_rst && ((m_ph == 0 && xfer_act && xfer_dir && !m_sdrv) || m_ph == 2);
    end
    started = 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R2 start", 64'(cmd_start), 64'(m_start));
      chk("R2 index", 64'(cmd_index), 64'(m_idx));
      chk("R2 arg", 64'(cmd_argument), 64'(m_arg));
      chk("R2 frame", 64'(cmd_frame), 64'({2'b01, 6'(m_idx), m_arg, 7'd0, 1'b1} & {48{m_idx != 0 || m_arg != 0 || m_start}}));
      chk("R5 inhibit", 64'(cmd_inhibit), 64'(m_inh));
      chk("R7 released", 64'(bus_released), 64'(m_rel));
      chk("R12 read_wait", 64'(read_wait_en), 64'(m_rw));
      chk("R12 busy_chk", 64'(busy_chk_en), 64'(m_bc));
      chk("R9 restart", 64'(wr_restart), 64'(m_rs));
      chk("R10 stop_rd", 64'(stop_buf_rd), 64'(m_srd));
      chk("R10 stop_drv", 64'(stop_dat_drv), 64'(m_sdrv));
    end
  end

  function automatic logic [15:0] mk(input int idx, input int typ);
    return {2'b00, 6'(idx), 2'(typ), 6'b0};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic [31:0] a);
    wr_en = 1; wr_be = be; wr_data = d; cmd_arg = a;
    tick();
    wr_en = 0; wr_be = 0;
  endtask

  task automatic fin(input bit ok);
    resp_done = 1; resp_ok = ok;
    tick();
    resp_done = 0; resp_ok = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 inhibit", 64'(cmd_inhibit), 64'd1);
    chk("R1 start", 64'(cmd_start), 64'd0);
    chk("R1 stops", 64'({stop_buf_rd, stop_dat_drv, bus_released}), 64'd0);

    // R2 and R6: normal command, full write
    wr(2'b11, mk(17, 0), 32'hDEADBEEF);
    chk("R2 start high", 64'(cmd_start), 64'd1);
    chk("R2 frame index", 64'(cmd_frame[45:40]), 64'd17);
    chk("R2 frame arg", 64'(cmd_frame[39:8]), 64'hDEADBEEF);
    tick();
    chk("R2 single pulse", 64'(cmd_start), 64'd0);
    fin(1);
    chk("R5 cleared", 64'(cmd_inhibit), 64'd0);
    chk("R6 normal no effect", 64'({bus_released, busy_chk_en, stop_buf_rd}), 64'd0);

    // R4: launch while inhibit is high
    wr(2'b11, mk(5, 0), 32'h11);
    wr(2'b11, mk(6, 0), 32'h22);
    chk("R4 second launch", 64'({cmd_start, cmd_index}), 64'({1'b1, 6'd6}));
    fin(1);

    // R3: lower-only stores type, upper-only uses it
    xfer_act = 1; xfer_dir = 0;
    tick();
    chk("R12 read wait on", 64'(read_wait_en), 64'd1);
    wr(2'b01, mk(0, 1), 32'h0);
    chk("R3 no start", 64'(cmd_start), 64'd0);
    wr(2'b10, {2'b00, 6'd52, 8'hFF}, 32'h33);
    chk("R3 upper launch", 64'({cmd_start, cmd_index}), 64'({1'b1, 6'd52}));
    fin(1);
    chk("R7 released", 64'(bus_released), 64'd1);
    chk("R7 read wait off", 64'(read_wait_en), 64'd0);
    chk("R3 low byte ignored", 64'(stop_buf_rd), 64'd0);

    // R9 resume for read
    wr(2'b11, mk(53, 2), 32'h0);
    fin(1);
    chk("R9 resume read", 64'({bus_released, read_wait_en}), 64'b01);

    // R8 failed suspend
    wr(2'b11, mk(52, 1), 32'h0);
    fin(0);
    chk("R8 unchanged", 64'({bus_released, read_wait_en}), 64'b01);
    tick();
    chk("R8 still unchanged", 64'({bus_released, read_wait_en}), 64'b01);

    // R9 resume for write with busy line
    xfer_dir = 1; dat_busy = 1;
    tick();
    chk("R12 busy chk on", 64'({busy_chk_en, read_wait_en}), 64'b10);
    wr(2'b11, mk(53, 2), 32'h0);
    fin(1);
    repeat (3) tick();
    chk("R9 held", 64'({wr_restart, busy_chk_en}), 64'b01);
    dat_busy = 0;
    tick();
    chk("R9 restart pulse", 64'(wr_restart), 64'd1);
    tick();
    chk("R9 pulse ends", 64'(wr_restart), 64'd0);

    // R10 aborts
    wr(2'b11, mk(12, 3), 32'h0);
    chk("R10 write abort", 64'({stop_dat_drv, stop_buf_rd, busy_chk_en}), 64'b100);
    fin(1);
    xfer_dir = 0;
    wr(2'b11, mk(12, 3), 32'h0);
    chk("R10 read abort", 64'({stop_buf_rd, read_wait_en}), 64'b10);
    fin(1);

    // R11 soft reset clears register and controls
    wr(2'b01, mk(0, 3), 32'h0);
    soft_rst = 1;
    tick();
    soft_rst = 0;
    chk("R11 cleared", 64'({stop_buf_rd, stop_dat_drv, read_wait_en}), 64'd0);
    chk("R11 inhibit kept", 64'(cmd_inhibit), 64'd0);
    wr(2'b10, mk(40, 0), 32'h44);
    chk("R11 type cleared", 64'(stop_buf_rd), 64'd0);
    tick();
    chk("R11 type cleared later", 64'(stop_buf_rd), 64'd0);
    fin(1);

    // R5 launch and completion together
    wr_en = 1; wr_be = 2'b11; wr_data = mk(9, 0); resp_done = 1; resp_ok = 1;
    tick();
    wr_en = 0; wr_be = 0; resp_done = 0; resp_ok = 0;
    chk("R5 launch wins", 64'(cmd_inhibit), 64'd1);
    fin(1);
    chk("R5 clears", 64'(cmd_inhibit), 64'd0);

    xfer_act = 0;
    repeat (3) tick();
    summary();
  end

endmodule